// File: doc/BRIEF.md
# Serial SAR Converter Read Controller

This block sits on the host side of a 12-bit successive-approximation converter with a three-wire serial port. It drives the active-low chip select and the serial clock, shifts in the converter's data line, and hands back each result as a right-aligned word together with a count of the bits that are valid. A start request opens a conversion frame. The frame length, counted in serial clocks, is programmable: 16 clocks give the full 12 bits, and fewer clocks end the conversion early with a lower resolution.

After reset the controller holds the select line high for a power-up interval. It then runs one full frame whose data is thrown away, because the converter's track-and-hold needs it to initialise. Between any two frames the select line stays high for a minimum acquisition interval. Start requests that arrive while a frame, the power-up wait, or an acquisition interval is in progress are held pending and served as soon as the interval ends. All intervals and the serial clock half-period are parameters counted in system clock cycles.

Top module: `sar_serial_reader`

## Requirements
- R1: While reset is held, and right after it, cs_n=1, sclk=1, busy=1, result_valid=0, result_data=0 and result_bits=0.
- R2: After reset is released cs_n stays high for exactly PWRUP_CYC cycles, then a dummy frame of 16 serial clocks runs, and no result_valid is raised for it.
- R3: In a frame of L clocks, cs_n goes low, sclk stays high for DIV_HALF cycles, then each clock is DIV_HALF cycles low followed by DIV_HALF cycles high, and cs_n rises at the end of the high phase of clock L; sclk only changes while cs_n is low.
- R4: sdata is captured in the cycle where sclk rises; with clocks numbered from 1, data seen on clocks 1 to 4 and beyond 16 is ignored, and clocks 5 to 16 carry result bits 11 down to 0, MSB first.
- R5: A frame of L clocks gives result_bits = L-4 for L from 5 to 16, 0 for L below 5 and 12 above 16; result_data holds those bits in its lowest positions with zeros above.
- R6: frame_len is taken when a frame begins, values 1 to 31 are clock counts, and 0 means 16.
- R7: result_valid is high for one cycle, the same cycle in which cs_n returns high; result_data and result_bits keep their values until the next result_valid.
- R8: Between two frames cs_n is high for at least ACQ_CYC cycles, whatever the frame length.
- R9: A start that arrives while busy is kept; a frame begins the cycle after the acquisition interval ends, and several such starts give only one frame.
- R10: busy is low only when the controller is idle and ready; a start seen while ready drives cs_n low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, sampled each cycle |
| frame_len | input | LEN_W | Serial clocks per frame, 0 means 16 |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles high |
| busy | output | 1 | Controller is not ready to begin a frame at once |
| result_valid | output | 1 | One-cycle strobe for a new result |
| result_data | output | RES_BITS | Right-aligned conversion result |
| result_bits | output | $clog2(RES_BITS+1) | Number of valid bits in result_data |

## Verification
The bench keeps a behavioural model of the frame timeline in integers: cs_n falls one cycle after an accepted start, sclk changes every DIV_HALF cycles after that, and result_valid is due DIV_HALF*(2L+1) cycles after cs_n fell, with the next frame no earlier than ACQ_CYC cycles later. The model is advanced on each rising clock edge from the same inputs the design sees, and all outputs are compared against it on the following falling edge, so each result is checked in exactly the cycle it is due. A converter model drives ones outside the data window, so any bit taken from a lead-in or trailing clock shows up as a wrong result word, which is checked against the value the converter latched at the falling select edge.

// File: rtl/sar_rd_pkg.sv
// Shared types and helpers for the serial converter read controller.
package sar_rd_pkg;

    // Phases of the controller, from power-up to ready.
    typedef enum logic [2:0] {
        ST_PWR   = 3'd0,
        ST_SETUP = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_GAP   = 3'd4,
        ST_READY = 3'd5
    } rd_state_t;

    // Largest of three cycle counts, used to size the shared timer.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sar_rd_ctrl.sv
// Frame sequencer: owns cs_n, sclk, the power-up wait, the dummy frame,
// the acquisition interval and the pending start request.
// Assumes DIV_HALF, PWRUP_CYC and ACQ_CYC are all at least 1 and that
// LEN_W is wide enough to hold FULL_CLKS.
module sar_rd_ctrl
    import sar_rd_pkg::*;
#(
    parameter int DIV_HALF  = 4,
    parameter int PWRUP_CYC = 312500,
    parameter int ACQ_CYC   = 25,
    parameter int FULL_CLKS = 16,
    parameter int LEN_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] frame_len_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             begin_o,
    output logic             sample_o,
    output logic [LEN_W-1:0] idx_o,
    output logic             finish_o
);

    localparam int TMAX = max3(DIV_HALF, PWRUP_CYC, ACQ_CYC);
    localparam int TW   = $clog2(TMAX + 1);

    rd_state_t        state;
    logic [TW-1:0]    tmr;
    logic [LEN_W-1:0] clk_no;
    logic [LEN_W-1:0] len_q;
    logic             dummy_q;
    logic             pend_q;
    logic             cs_q;
    logic             sclk_q;
    logic             tmr_last;
    logic             go;
    logic             frame_end;

    // Timer end condition depends on which interval the current phase measures.
    always_comb begin
        unique case (state)
            ST_PWR:  tmr_last = (tmr == TW'(PWRUP_CYC - 1));
            ST_GAP:  tmr_last = (tmr == TW'(ACQ_CYC - 1));
            default: tmr_last = (tmr == TW'(DIV_HALF - 1));
        endcase
    end

    // Frame begin, frame end and sampling strobes.
    always_comb begin
        go        = ((state == ST_READY) && start_i) ||
                    ((state == ST_GAP) && tmr_last && (start_i || pend_q));
        frame_end = (state == ST_HIGH) && tmr_last && (clk_no == len_q);
        begin_o   = go || ((state == ST_PWR) && tmr_last);
        sample_o  = (state == ST_LOW) && tmr_last;
        finish_o  = frame_end && !dummy_q;
    end

    // Phase sequencing, serial clock generation and request bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_PWR;
            tmr     <= '0;
            clk_no  <= '0;
            len_q   <= LEN_W'(FULL_CLKS);
            dummy_q <= 1'b1;
            pend_q  <= 1'b0;
            cs_q    <= 1'b1;
            sclk_q  <= 1'b1;
        end else begin
            pend_q <= go ? 1'b0 : (pend_q | start_i);
            tmr    <= tmr + TW'(1);
            unique case (state)
                ST_PWR: if (tmr_last) begin
                    state   <= ST_SETUP;
                    tmr     <= '0;
                    cs_q    <= 1'b0;
                    dummy_q <= 1'b1;
                    len_q   <= LEN_W'(FULL_CLKS);
                end
                ST_SETUP: if (tmr_last) begin
                    state  <= ST_LOW;
                    tmr    <= '0;
                    sclk_q <= 1'b0;
                    clk_no <= LEN_W'(1);
                end
                ST_LOW: if (tmr_last) begin
                    state  <= ST_HIGH;
                    tmr    <= '0;
                    sclk_q <= 1'b1;
                end
                ST_HIGH: if (tmr_last) begin
                    tmr <= '0;
                    if (frame_end) begin
                        state <= ST_GAP;
                        cs_q  <= 1'b1;
                    end else begin
                        state  <= ST_LOW;
                        sclk_q <= 1'b0;
                        clk_no <= clk_no + LEN_W'(1);
                    end
                end
                ST_GAP: if (tmr_last) begin
                    state <= ST_READY;
                end
                ST_READY: tmr <= '0;
                default: state <= ST_PWR;
            endcase
            if (go) begin
                state   <= ST_SETUP;
                tmr     <= '0;
                cs_q    <= 1'b0;
                dummy_q <= 1'b0;
                len_q   <= (frame_len_i == '0) ? LEN_W'(FULL_CLKS) : frame_len_i;
            end
        end
    end

    assign cs_n_o = cs_q;
    assign sclk_o = sclk_q;
    assign busy_o = (state != ST_READY);
    assign idx_o  = clk_no;

    // R3
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_q) |-> (!cs_q && !$past(cs_q)));

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY) |-> (cs_q && sclk_q));

endmodule

// File: rtl/sar_rd_capture.sv
// Result assembly: shifts in data bits inside the result window, counts
// them, and registers the right-aligned word when a frame completes.
// Assumes sdata_i is stable for the half-period before each sample strobe.
module sar_rd_capture #(
    parameter int RES_BITS  = 12,
    parameter int LEAD_CLKS = 4,
    parameter int LEN_W     = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         begin_i,
    input  logic                         sample_i,
    input  logic [LEN_W-1:0]             idx_i,
    input  logic                         sdata_i,
    input  logic                         finish_i,
    output logic                         valid_o,
    output logic [RES_BITS-1:0]          data_o,
    output logic [$clog2(RES_BITS+1)-1:0] bits_o
);

    localparam int RW = $clog2(RES_BITS + 1);

    logic [RES_BITS-1:0] sh_q;
    logic [RW-1:0]       cnt_q;
    logic                in_window;

    // A clock carries a result bit only between the lead-in and the last bit.
    assign in_window = (int'(idx_i) > LEAD_CLKS) &&
                       (int'(idx_i) <= LEAD_CLKS + RES_BITS);

    // Shift register and bit count for the frame in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (begin_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (sample_i && in_window) begin
            sh_q  <= {sh_q[RES_BITS-2:0], sdata_i};
            cnt_q <= cnt_q + RW'(1);
        end
    end

    // Output registers, loaded only by a completed reported frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            bits_o  <= '0;
        end else begin
            valid_o <= finish_i;
            if (finish_i) begin
                data_o <= sh_q;
                bits_o <= cnt_q;
            end
        end
    end

    // R5
    bits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bits_o) <= RES_BITS));

    // R5
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((int'(bits_o) == RES_BITS) ||
                     ((data_o >> bits_o) == '0)));

endmodule

// File: rtl/sar_serial_reader.sv
// Top of the serial converter read controller: joins the frame sequencer
// and the result assembly. Times are in system clock cycles; defaults
// suit a 125 MHz system clock (about 15.6 MHz serial clock, 200 ns
// acquisition, 2.5 ms power-up). Assumes PWRUP_CYC >= ACQ_CYC.
module sar_serial_reader #(
    parameter int DIV_HALF  = 4,
    parameter int PWRUP_CYC = 312500,
    parameter int ACQ_CYC   = 25,
    parameter int RES_BITS  = 12,
    parameter int LEAD_CLKS = 4,
    parameter int LEN_W     = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [LEN_W-1:0]              frame_len,
    input  logic                          sdata,
    output logic                          cs_n,
    output logic                          sclk,
    output logic                          busy,
    output logic                          result_valid,
    output logic [RES_BITS-1:0]           result_data,
    output logic [$clog2(RES_BITS+1)-1:0] result_bits
);

    localparam int FULL_CLKS = LEAD_CLKS + RES_BITS;

    logic             frm_begin;
    logic             frm_sample;
    logic [LEN_W-1:0] frm_idx;
    logic             frm_finish;

    sar_rd_ctrl #(
        .DIV_HALF  (DIV_HALF),
        .PWRUP_CYC (PWRUP_CYC),
        .ACQ_CYC   (ACQ_CYC),
        .FULL_CLKS (FULL_CLKS),
        .LEN_W     (LEN_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .frame_len_i (frame_len),
        .cs_n_o      (cs_n),
        .sclk_o      (sclk),
        .busy_o      (busy),
        .begin_o     (frm_begin),
        .sample_o    (frm_sample),
        .idx_o       (frm_idx),
        .finish_o    (frm_finish)
    );

    sar_rd_capture #(
        .RES_BITS  (RES_BITS),
        .LEAD_CLKS (LEAD_CLKS),
        .LEN_W     (LEN_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .begin_i  (frm_begin),
        .sample_i (frm_sample),
        .idx_i    (frm_idx),
        .sdata_i  (sdata),
        .finish_i (frm_finish),
        .valid_o  (result_valid),
        .data_o   (result_data),
        .bits_o   (result_bits)
    );

    // Length of the current run of cs_n high, saturating; feeds the gap check.
    logic [31:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run <= '0;
        else if (!cs_n)
            hi_run <= '0;
        else if (hi_run != '1)
            hi_run <= hi_run + 32'd1;
    end

    // R7
    valid_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (cs_n && !$past(cs_n)));

    // R8
    acq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_run >= 32'(ACQ_CYC)));

endmodule

// File: tb/sar_serial_reader_test.sv
`timescale 1ns/1ps
module sar_serial_reader_test;

    localparam int H    = 3;
    localparam int P    = 40;
    localparam int A    = 7;
    localparam int RES  = 12;
    localparam int LEAD = 4;
    localparam int FULL = 16;
    localparam int LW   = 5;
    localparam int RW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] frame_len = 5'd16;
    logic          sdata;
    logic          cs_n, sclk, busy, result_valid;
    logic [RES-1:0] result_data;
    logic [RW-1:0]  result_bits;

    always #4 clk = ~clk;

    sar_serial_reader #(
        .DIV_HALF(H), .PWRUP_CYC(P), .ACQ_CYC(A),
        .RES_BITS(RES), .LEAD_CLKS(LEAD), .LEN_W(LW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .busy(busy),
        .result_valid(result_valid), .result_data(result_data),
        .result_bits(result_bits)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_valid = 0;
    int n_frames = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", what, act, exp, $time);
        end
    endtask

    // Converter model: latches a value at select fall, ones outside the window.
    int       fcnt = 0;
    logic [RES-1:0] conv_val = '0;
    always @(negedge cs_n) begin
        fcnt = 0;
        conv_val = RES'((32'h5A3 ^ (n_frames * 32'h1F7)) & 32'hFFF);
        n_frames++;
    end
    always @(negedge sclk) if (!cs_n) fcnt++;
    always_comb begin
        if (cs_n) sdata = 1'b0;
        else if (fcnt > LEAD && fcnt <= FULL) sdata = conv_val[FULL - fcnt];
        else sdata = 1'b1;
    end

    // Reference timeline: 0 power-up, 1 frame, 2 gap, 3 ready.
    int m_mode = 0, m_t = 0, m_L = FULL, m_last_L = FULL;
    bit m_dummy = 1, m_pend = 0, m_go = 0, started = 0;
    bit e_cs = 1, e_sclk = 1, e_busy = 1, e_valid = 0;
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_mode = 0; m_t = 0; m_pend = 0; m_dummy = 1; m_L = FULL; e_valid = 0;
        end else begin
            m_go = 0; e_valid = 0;
            case (m_mode)
                0: if (m_t == P - 1) begin m_mode = 1; m_t = 0; m_L = FULL; m_dummy = 1; end
                   else m_t++;
                1: if (m_t == H + 2 * H * m_L - 1) begin
                       m_mode = 2; m_t = 0; m_last_L = m_L;
                       if (!m_dummy) e_valid = 1;
                   end else m_t++;
                2: if (m_t == A - 1) begin
                       if (m_pend || start) m_go = 1; else m_mode = 3;
                   end else m_t++;
                default: if (start) m_go = 1;
            endcase
            if (m_go) begin
                m_mode = 1; m_t = 0; m_dummy = 0; m_pend = 0;
                m_L = (frame_len == 0) ? FULL : int'(frame_len);
            end else if (start) m_pend = 1;
        end
        e_cs   = (m_mode != 1);
        e_busy = (m_mode != 3);
        if (m_mode != 1 || m_t < H) e_sclk = 1;
        else e_sclk = (((m_t - H) / H) % 2 == 0) ? 1'b0 : 1'b1;
    end

    // Per-cycle comparison on the falling edge.
    logic [RES-1:0] hold_data = '0;
    int hold_bits = 0;
    always @(negedge clk) begin
        if (started && !finished) begin
            if (e_valid) begin
                int lc;
                lc = (m_last_L > FULL) ? FULL : m_last_L;
                hold_bits = (lc > LEAD) ? lc - LEAD : 0;
                hold_data = conv_val >> (RES - hold_bits);
                n_valid++;
            end
            chk(cs_n === e_cs, "R2/R3/R8/R9 cs_n", int'(cs_n), int'(e_cs));
            chk(sclk === e_sclk, "R3 sclk", int'(sclk), int'(e_sclk));
            chk(busy === e_busy, "R10 busy", int'(busy), int'(e_busy));
            chk(result_valid === e_valid, "R7/R2 result_valid", int'(result_valid), int'(e_valid));
            chk(result_data === hold_data, "R4/R5/R6 result_data", int'(result_data), int'(hold_data));
            chk(int'(result_bits) == hold_bits, "R5/R6 result_bits", int'(result_bits), hold_bits);
        end
    end

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic run_frame(input int len);
        @(negedge clk);
        frame_len = LW'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: start while ready drops cs_n in the next cycle
        chk(cs_n === 1'b0, "R10 start latency", int'(cs_n), 0);
        wait_idle();
    endtask

    initial begin
        int v0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(cs_n === 1'b1 && sclk === 1'b1 && busy === 1'b1, "R1 reset pins",
            int'({cs_n, sclk, busy}), 7);
        chk(result_valid === 1'b0 && result_data === '0, "R1 reset result",
            int'(result_data), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        frame_len = 5'd16;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        // R2 and R9: dummy frame plus one held request, one result
        chk(n_frames == 2, "R2/R9 frames after power-up", n_frames, 2);
        chk(n_valid == 1, "R2 dummy frame not reported", n_valid, 1);

        run_frame(16);
        run_frame(12);
        run_frame(7);
        run_frame(4);
        run_frame(1);
        run_frame(0);   // R6: zero means 16
        run_frame(20);  // R4: trailing clocks ignored
        run_frame(31);
        run_frame(5);

        // R9: burst of starts during a frame yields one extra frame
        v0 = n_valid;
        @(negedge clk); frame_len = 5'd9; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            start = 1'b1; @(negedge clk); start = 1'b0; repeat (4) @(negedge clk);
        end
        wait_idle();
        chk(n_valid - v0 == 2, "R9 collapsed requests", n_valid - v0, 2);

        // R8/R9: start held high, frames back to back with the gap kept
        v0 = n_valid;
        @(negedge clk); frame_len = 5'd6; start = 1'b1;
        repeat (300) @(negedge clk);
        start = 1'b0;
        wait_idle();
        chk(n_valid - v0 >= 4, "R8 back-to-back frames", n_valid - v0, 4);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 act=%0d exp=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule